// File: doc/BRIEF.md
# System Exception Pending Register

This block holds the pending state of three system exceptions: the non-maskable interrupt (exception 2), the deferred service call (exception 14) and the periodic tick (exception 15). It is presented as one 32-bit memory-mapped word. Software makes each of these exceptions pending by writing 1 to a set bit. The service call and the tick each also have a separate clear bit that software writes with 1. Writing 0 to any control bit leaves the state as it is. Hardware can also make an exception pending. A non-maskable request input sets the NMI bit, and a tick event input sets the tick bit. The deferred service call can only be made pending by a software write.

An exception-entry acknowledge carries the number of the exception that is being taken, and it clears that exception's pending bit. The block also takes the pending and enable vectors of the external interrupts, together with 2-bit priorities for the service call, the tick and every external interrupt. From these it works out which pending, enabled exception is the most urgent. It places that exception's number in a read-only field of the word. The field is registered, so it stays steady while a read is in progress.

Top module: `exc_pend_ctrl`

## Requirements
- R1: After reset, every bit of `reg_rdata` reads 0. This covers the three pending bits and the 6-bit vector field.
- R2: A write with bit 31 set makes the NMI pending, and bit 31 reads 1 from the next cycle. A 1 on `nmi_req` has the same effect. Writing 0 to bit 31 has no effect.
- R3: An acknowledge with `ack_num` = 2 clears the NMI pending bit. If a software set or an `nmi_req` arrives in the same cycle, the bit stays set.
- R4: A write with bit 28 set makes the deferred call pending, and it reads back on bit 28. A write with bit 27 set clears it. No input other than a software write can make it pending.
- R5: A write with bit 26 set makes the tick pending, and it reads back on bit 26. A 1 on `tick_evt` does the same. A write with bit 25 set clears it.
- R6: An acknowledge with `ack_num` = 14 clears the deferred-call pending bit. An acknowledge with `ack_num` = 15 clears the tick pending bit.
- R7: A single write that sets both the set bit and the clear bit of the same exception leaves that exception pending. While such a write is presented, `set_clr_conflict` is 1.
- R8: Bits 30:29, 27, 25, 24:18 and 11:0 always read 0. Writes to these bits have no effect on the state.
- R9: Bits 17:12 hold the current vector, `vect_pending` holds the same value. While the NMI is pending, the vector is 2.
- R10: When the NMI is not pending, the vector is the number of the pending, enabled source with the lowest priority value. External interrupt k counts as number k+16. When priority values are equal, the lower number wins. An external interrupt whose enable is 0 is not considered.
- R11: When nothing is pending and enabled, the vector is 0. The vector changes exactly one clock edge after the pending state or the interrupt inputs change. It does not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| nmi_req | input | 1 | Hardware request that makes the NMI pending |
| tick_evt | input | 1 | Hardware tick event that makes the tick pending |
| ack_valid | input | 1 | Exception entry acknowledge |
| ack_num | input | 6 | Number of the exception being entered |
| psv_prio | input | 2 | Priority of the deferred call |
| tck_prio | input | 2 | Priority of the tick |
| irq_pend | input | NUM_IRQ | Pending vector of the external interrupts |
| irq_en | input | NUM_IRQ | Enable vector of the external interrupts |
| irq_prio | input | NUM_IRQ*2 | Priorities of the external interrupts; interrupt k uses bits 2k+1:2k |
| vect_pending | output | 6 | Registered winning exception number |
| set_clr_conflict | output | 1 | The current write sets and clears the same exception |

## Verification
The hardest cases to reach from the ports are the ones where two events land in the same cycle. One is an NMI acknowledge that coincides with a fresh request. The others are writes that set and clear the same exception at once. The stimulus table drives these combinations in a single cycle, and each is then followed by one idle cycle so that the registered vector can settle. Arbitration ties between a system source and an external interrupt are set up by directed steps. These steps change the priority and enable inputs while the pending state is held. Each step also confirms that the vector keeps its old value until the next edge.

// File: rtl/exc_pend_pkg.sv
package exc_pend_pkg;
   localparam int REG_W     = 32;
   localparam int B_NMI_SET = 31;
   localparam int B_PSV_SET = 28;
   localparam int B_PSV_CLR = 27;
   localparam int B_TCK_SET = 26;
   localparam int B_TCK_CLR = 25;
   localparam int VEC_LSB   = 12;

   localparam int EXC_NMI   = 2;
   localparam int EXC_PSV   = 14;
   localparam int EXC_TCK   = 15;
   localparam int IRQ_BASE  = 16;

   typedef struct packed {
      logic nmi;
      logic psv;
      logic tck;
   } pend_t;

   typedef struct packed {
      logic nmi_set;
      logic psv_set;
      logic psv_clr;
      logic tck_set;
      logic tck_clr;
   } wr_cmd_t;
endpackage

// File: rtl/epc_pend_bits.sv
module epc_pend_bits
   import exc_pend_pkg::*;
#(
   parameter int VEC_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  wr_cmd_t          wr_cmd,
   input  logic             nmi_req,
   input  logic             tick_evt,
   input  logic             ack_valid,
   input  logic [VEC_W-1:0] ack_num,
   output pend_t            pend_q,
   output logic             conflict
);
   logic nmi_set, psv_set, psv_clr, tck_set, tck_clr;
   logic ack_nmi, ack_psv, ack_tck;

   assign nmi_set = wr_en & wr_cmd.nmi_set;
   assign psv_set = wr_en & wr_cmd.psv_set;
   assign psv_clr = wr_en & wr_cmd.psv_clr;
   assign tck_set = wr_en & wr_cmd.tck_set;
   assign tck_clr = wr_en & wr_cmd.tck_clr;

   assign ack_nmi = ack_valid && (ack_num == VEC_W'(EXC_NMI));
   assign ack_psv = ack_valid && (ack_num == VEC_W'(EXC_PSV));
   assign ack_tck = ack_valid && (ack_num == VEC_W'(EXC_TCK));

   assign conflict = (psv_set & psv_clr) | (tck_set & tck_clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         pend_q.nmi <= nmi_set | nmi_req | (pend_q.nmi & ~ack_nmi);
         if (psv_set)
            pend_q.psv <= 1'b1;
         else if (psv_clr | ack_psv)
            pend_q.psv <= 1'b0;
         if (tck_set | tick_evt)
            pend_q.tck <= 1'b1;
         else if (tck_clr | ack_tck)
            pend_q.tck <= 1'b0;
      end
   end

   a_r2_nmi_set: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_set || nmi_req) |=> pend_q.nmi);
   a_r3_nmi_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_nmi && !nmi_set && !nmi_req) |=> !pend_q.nmi);
   a_r4_psv_sw_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!psv_set && !pend_q.psv) |=> !pend_q.psv);
   a_r5_tick_evt: assert property (@(posedge clk) disable iff (!rst_n)
      tick_evt |=> pend_q.tck);
   a_r6_psv_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_psv && !psv_set) |=> !pend_q.psv);
   a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (conflict && psv_set) |=> pend_q.psv);
endmodule

// File: rtl/epc_arbiter.sv
module epc_arbiter
   import exc_pend_pkg::*;
#(
   parameter int NUM_IRQ = 8,
   parameter int PRIO_W  = 2,
   parameter int VEC_W   = 6
) (
   input  pend_t                       pend,
   input  logic [PRIO_W-1:0]           psv_prio,
   input  logic [PRIO_W-1:0]           tck_prio,
   input  logic [NUM_IRQ-1:0]          irq_pend,
   input  logic [NUM_IRQ-1:0]          irq_en,
   input  logic [NUM_IRQ*PRIO_W-1:0]   irq_prio,
   output logic [VEC_W-1:0]            win_num,
   output logic                        any_pend
);
   localparam int NCAND = NUM_IRQ + 2;

   logic [NCAND-1:0]             cand_vld;
   logic [NCAND-1:0][PRIO_W-1:0] cand_prio;
   logic [NCAND-1:0][VEC_W-1:0]  cand_num;

   assign cand_vld[0]  = pend.psv;
   assign cand_prio[0] = psv_prio;
   assign cand_num[0]  = VEC_W'(EXC_PSV);
   assign cand_vld[1]  = pend.tck;
   assign cand_prio[1] = tck_prio;
   assign cand_num[1]  = VEC_W'(EXC_TCK);

   for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
      assign cand_vld[k+2]  = irq_pend[k] & irq_en[k];
      assign cand_prio[k+2] = irq_prio[k*PRIO_W +: PRIO_W];
      assign cand_num[k+2]  = VEC_W'(IRQ_BASE + k);
   end

   logic              best_vld;
   logic [PRIO_W-1:0] best_prio;
   logic [VEC_W-1:0]  best_num;

   // candidates are in ascending exception number, so a strict compare keeps ties low
   always_comb begin
      best_vld  = 1'b0;
      best_prio = '0;
      best_num  = '0;
      for (int i = 0; i < NCAND; i++) begin
         if (cand_vld[i] && (!best_vld || (cand_prio[i] < best_prio))) begin
            best_vld  = 1'b1;
            best_prio = cand_prio[i];
            best_num  = cand_num[i];
         end
      end
   end

   assign any_pend = pend.nmi | best_vld;
   assign win_num  = pend.nmi ? VEC_W'(EXC_NMI) : best_num;
endmodule

// File: rtl/epc_vec_reg.sv
module epc_vec_reg #(
   parameter int VEC_W    = 6,
   parameter bit REG_VECT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VEC_W-1:0] win_num,
   input  logic             any_pend,
   output logic [VEC_W-1:0] vect_q
);
   if (REG_VECT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            vect_q <= '0;
         else
            vect_q <= any_pend ? win_num : '0;
      end

      a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
         !any_pend |=> (vect_q == '0));
      a_r11_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
         any_pend |=> (vect_q == $past(win_num)));
   end else begin : g_comb
      assign vect_q = any_pend ? win_num : '0;
   end
endmodule

// File: rtl/exc_pend_ctrl.sv
module exc_pend_ctrl
   import exc_pend_pkg::*;
#(
   parameter int NUM_IRQ  = 8,
   parameter int PRIO_W   = 2,
   parameter int VEC_W    = 6,
   parameter bit REG_VECT = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_wr_en,
   input  logic [REG_W-1:0]          reg_wdata,
   output logic [REG_W-1:0]          reg_rdata,
   input  logic                      nmi_req,
   input  logic                      tick_evt,
   input  logic                      ack_valid,
   input  logic [VEC_W-1:0]          ack_num,
   input  logic [PRIO_W-1:0]         psv_prio,
   input  logic [PRIO_W-1:0]         tck_prio,
   input  logic [NUM_IRQ-1:0]        irq_pend,
   input  logic [NUM_IRQ-1:0]        irq_en,
   input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
   output logic [VEC_W-1:0]          vect_pending,
   output logic                      set_clr_conflict
);
   if (NUM_IRQ < 1 || PRIO_W < 1 || IRQ_BASE + NUM_IRQ > (1 << VEC_W)
       || VEC_LSB + VEC_W > 18) begin : g_bad_cfg
      $error("exc_pend_ctrl: parameter set does not fit the register layout");
   end

   wr_cmd_t wr_cmd;
   pend_t   pend_q;
   logic [VEC_W-1:0] win_num;
   logic             any_pend;

   assign wr_cmd.nmi_set = reg_wdata[B_NMI_SET];
   assign wr_cmd.psv_set = reg_wdata[B_PSV_SET];
   assign wr_cmd.psv_clr = reg_wdata[B_PSV_CLR];
   assign wr_cmd.tck_set = reg_wdata[B_TCK_SET];
   assign wr_cmd.tck_clr = reg_wdata[B_TCK_CLR];

   logic unused_wdata;
   assign unused_wdata = ^{reg_wdata[30:29], reg_wdata[24:0]};

   epc_pend_bits #(.VEC_W(VEC_W)) u_bits (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr_en),
      .wr_cmd    (wr_cmd),
      .nmi_req   (nmi_req),
      .tick_evt  (tick_evt),
      .ack_valid (ack_valid),
      .ack_num   (ack_num),
      .pend_q    (pend_q),
      .conflict  (set_clr_conflict)
   );

   epc_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_arb (
      .pend     (pend_q),
      .psv_prio (psv_prio),
      .tck_prio (tck_prio),
      .irq_pend (irq_pend),
      .irq_en   (irq_en),
      .irq_prio (irq_prio),
      .win_num  (win_num),
      .any_pend (any_pend)
   );

   epc_vec_reg #(.VEC_W(VEC_W), .REG_VECT(REG_VECT)) u_vec (
      .clk      (clk),
      .rst_n    (rst_n),
      .win_num  (win_num),
      .any_pend (any_pend),
      .vect_q   (vect_pending)
   );

   always_comb begin
      reg_rdata                          = '0;
      reg_rdata[B_NMI_SET]               = pend_q.nmi;
      reg_rdata[B_PSV_SET]               = pend_q.psv;
      reg_rdata[B_TCK_SET]               = pend_q.tck;
      reg_rdata[VEC_LSB +: VEC_W]        = vect_pending;
   end

   a_r9_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q.nmi |=> (vect_pending == VEC_W'(EXC_NMI)));
   a_r8_wo_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[B_PSV_CLR] == 1'b0) && (reg_rdata[B_TCK_CLR] == 1'b0));
endmodule

// File: tb/exc_pend_ctrl_tb.sv
module exc_pend_ctrl_tb;
   localparam int NI = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        nmi_req = 1'b0;
   logic        tick_evt = 1'b0;
   logic        ack_valid = 1'b0;
   logic [5:0]  ack_num = '0;
   logic [1:0]  psv_prio = 2'd1;
   logic [1:0]  tck_prio = 2'd1;
   logic [NI-1:0]   irq_pend = '0;
   logic [NI-1:0]   irq_en = '0;
   logic [NI*2-1:0] irq_prio = '0;
   logic [5:0]  vect_pending;
   logic        set_clr_conflict;

   always #10 clk = ~clk;

   exc_pend_ctrl #(.NUM_IRQ(NI)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .nmi_req(nmi_req), .tick_evt(tick_evt),
      .ack_valid(ack_valid), .ack_num(ack_num), .psv_prio(psv_prio),
      .tck_prio(tck_prio), .irq_pend(irq_pend), .irq_en(irq_en),
      .irq_prio(irq_prio), .vect_pending(vect_pending),
      .set_clr_conflict(set_clr_conflict)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // {wr, wdata, nmi_req, tick, ack_v, ack_num, conflict, expected rdata}
   localparam int NV = 18;
   localparam logic [74:0] VECS [NV] = '{
      {1'b1, 32'h61FF_FFFF, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 32'h0000_0000}, // R8
      {1'b1, 32'h1000_0000, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 32'h1000_E000}, // R4
      {1'b1, 32'h0400_0000, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 32'h1400_E000}, // R5 R10 tie
      {1'b1, 32'h0800_0000, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 32'h0400_F000}, // R4 clear
      {1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 6'd15, 1'b0, 32'h0000_0000}, // R6
      {1'b0, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 6'd0,  1'b0, 32'h0400_F000}, // R5 event
      {1'b1, 32'h0200_0000, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 32'h0000_0000}, // R5 clear
      {1'b0, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 6'd0,  1'b0, 32'h8000_2000}, // R2 hw
      {1'b1, 32'h1000_0000, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 32'h9000_2000}, // R9
      {1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 6'd2,  1'b0, 32'h1000_E000}, // R3
      {1'b1, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 32'h9000_2000}, // R2 sw
      {1'b0, 32'h0000_0000, 1'b1, 1'b0, 1'b1, 6'd2,  1'b0, 32'h9000_2000}, // R3 re-request
      {1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 6'd2,  1'b0, 32'h1000_E000}, // R3
      {1'b1, 32'h1800_0000, 1'b0, 1'b0, 1'b0, 6'd0,  1'b1, 32'h1000_E000}, // R7
      {1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 6'd14, 1'b0, 32'h0000_0000}, // R6
      {1'b1, 32'h0600_0000, 1'b0, 1'b0, 1'b0, 6'd0,  1'b1, 32'h0400_F000}, // R7
      {1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 32'h0400_F000}, // R2 zero write
      {1'b1, 32'h0200_0000, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 32'h0000_0000}  // R5
   };

   task automatic idle_inputs();
      reg_wr_en = 1'b0;
      reg_wdata = '0;
      nmi_req   = 1'b0;
      tick_evt  = 1'b0;
      ack_valid = 1'b0;
      ack_num   = '0;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset", reg_rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", reg_rdata, 32'h0);

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         reg_wr_en = VECS[v][74];
         reg_wdata = VECS[v][73:42];
         nmi_req   = VECS[v][41];
         tick_evt  = VECS[v][40];
         ack_valid = VECS[v][39];
         ack_num   = VECS[v][38:33];
         #1;
         chk("R7 conflict flag", {31'b0, set_clr_conflict}, {31'b0, VECS[v][32]});
         @(negedge clk);
         idle_inputs();
         @(negedge clk);
         chk($sformatf("R9 R11 vector %0d", v), reg_rdata, VECS[v][31:0]);
      end

      // R10: external interrupts, irq3 prio 2, irq5 prio 1
      @(negedge clk);
      irq_prio = 16'h0480;
      irq_en   = 8'b0010_1000;
      irq_pend = 8'b0010_1000;
      #1;
      chk("R11 stable between edges", {26'b0, vect_pending}, 32'd0);
      @(negedge clk);
      chk("R10 lower prio value wins", {26'b0, vect_pending}, 32'd21);
      irq_en = 8'b0000_1000;
      @(negedge clk);
      chk("R10 disabled irq ignored", {26'b0, vect_pending}, 32'd19);
      irq_prio = 16'h0040;
      reg_wr_en = 1'b1;
      reg_wdata = 32'h1000_0000;
      @(negedge clk);
      idle_inputs();
      @(negedge clk);
      chk("R10 tie goes to lower number", reg_rdata, 32'h1000_E000);
      psv_prio = 2'd2;
      @(negedge clk);
      chk("R10 priority beats number", reg_rdata, 32'h1001_3000);
      reg_wr_en = 1'b1;
      reg_wdata = 32'h0800_0000;
      irq_en    = '0;
      @(negedge clk);
      idle_inputs();
      @(negedge clk);
      chk("R11 zero when nothing enabled", reg_rdata, 32'h0);
      chk("R11 vect port", {26'b0, vect_pending}, 32'd0);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule